// File: doc/BRIEF.md
# Maskable BCD Alarm Comparator

This block watches a calendar that is kept elsewhere and raises an alarm when the time reaches a programmed point. The current seconds, minutes, hours, day of week, day of month and month come in as BCD bytes, together with a one-cycle strobe that marks each seconds update. Six byte-wide alarm registers hold a BCD target for each field. Each register also has a compare-enable bit, so any field can be left as don't-care.

On each seconds strobe the block checks every enabled field against the time. If at least one field is enabled and all enabled fields match, it sets a sticky alarm flag. The flag stays set until software writes it to zero. An interrupt output is the flag gated by an interrupt-enable bit. Software reads and writes the alarm registers and the control byte through a simple byte-wide register port. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `bcd_alarm_match`

## Requirements
- R1: After reset, every alarm register, the alarm flag and the interrupt enable read 0, and `alarm_irq` is 0.
- R2: Register indices 8 to 13 hold the alarm bytes for seconds, minutes, hours, day of week, day of month and month, in that order. A write stores the full byte and a read returns it.
- R3: Bit 7 of an alarm byte enables its field. An enabled field matches only when bits 6..0 equal bits 6..0 of the current-time byte and bit 7 of that time byte is 0. A one-digit difference is a mismatch.
- R4: A field whose bit 7 is clear is don't-care. Its stored value has no effect on the alarm, and a register written as 0 disables its field.
- R5: The flag sets in the cycle after a seconds strobe on which all enabled fields match and at least one field is enabled. With no field enabled it never sets.
- R6: Matching is evaluated only on a seconds strobe. A time held equal to the alarm with no strobe does not set the flag.
- R7: Once set, the flag stays at 1 until software writes the control byte with bit 0 = 0. Writing bit 0 = 1 never sets the flag.
- R8: If a set event and a software clear of the flag fall in the same cycle, the flag ends at 1.
- R9: `alarm_irq` is 1 exactly when the flag is 1 and the interrupt enable is 1.
- R10: The control byte at index 14 reads with the flag in bit 0 and the interrupt enable in bit 3, which a write loads directly. Its other bits read 0. Every other index reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle strobe marking a seconds update |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_wday | input | 8 | Current day of week, BCD |
| cur_mday | input | 8 | Current day of month, BCD |
| cur_mon | input | 8 | Current month, BCD |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The bench sets a seconds strobe and a control-byte clear in the same cycle. A design that lets the clear win loses that alarm for good. It holds a matching time with no strobe after a clear. A level-sensitive compare would set the flag again on every cycle of that hold. It fires a strobe with every field disabled, where a plain AND over the fields would trigger at once. It also uses fields that hold a stale value with the enable clear, and times that differ from an enabled field by one digit, to catch a compare that ignores the enable bit or tests too few bits. Random alarm settings, with times that mostly match, are checked against a model of the enabled-field rule.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
  localparam int unsigned FIELD_CNT = 6;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned ADDR_W    = 4;
  // Register indices; alarm bytes occupy ALM_BASE .. ALM_BASE+FIELD_CNT-1
  localparam int unsigned ALM_BASE  = 8;
  localparam int unsigned CTRL_IDX  = 14;
  // Control byte bit positions
  localparam int unsigned FLAG_BIT  = 0;
  localparam int unsigned IE_BIT    = 3;

  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_WDAY = 3'd3,
    FLD_MDAY = 3'd4,
    FLD_MON  = 3'd5
  } field_e;
endpackage

// File: rtl/bcd_alarm_regs.sv
module bcd_alarm_regs #(
  parameter int unsigned NFIELD = 6,
  parameter int unsigned DW     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NFIELD-1:0]            wr_sel,
  input  logic [DW-1:0]                wr_data,
  output logic [NFIELD-1:0][DW-1:0]    alm_q
);
  for (genvar g = 0; g < NFIELD; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         alm_q[g] <= '0;
      else if (wr_sel[g]) alm_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/bcd_alarm_field_cmp.sv
module bcd_alarm_field_cmp #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] alm,
  input  logic [DW-1:0] cur,
  output logic          fld_en,
  output logic          fld_ok
);
  logic eq;
  always_comb begin
    fld_en = alm[DW-1];
    eq     = (alm[DW-2:0] == cur[DW-2:0]) && !cur[DW-1];
    fld_ok = !fld_en || eq;
  end
endmodule

// File: rtl/bcd_alarm_cmp_array.sv
module bcd_alarm_cmp_array #(
  parameter int unsigned NFIELD = 6,
  parameter int unsigned DW     = 8
) (
  input  logic [NFIELD-1:0][DW-1:0] alm,
  input  logic [NFIELD-1:0][DW-1:0] cur,
  output logic                      any_en,
  output logic                      hit
);
  logic [NFIELD-1:0] en_v;
  logic [NFIELD-1:0] ok_v;

  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    bcd_alarm_field_cmp #(.DW(DW)) u_cmp (
      .alm    (alm[g]),
      .cur    (cur[g]),
      .fld_en (en_v[g]),
      .fld_ok (ok_v[g])
    );
  end

  always_comb begin
    any_en = |en_v;
    hit    = any_en && (&ok_v);
  end
endmodule

// File: rtl/bcd_alarm_flag.sv
module bcd_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit,
  input  logic ctrl_wr,
  input  logic wr_flag_bit,
  input  logic wr_ie_bit,
  output logic flag_q,
  output logic ie_q
);
  logic set_evt;
  logic clr_evt;
  always_comb begin
    set_evt = tick && hit;
    clr_evt = ctrl_wr && !wr_flag_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      if (set_evt)      flag_q <= 1'b1;
      else if (clr_evt) flag_q <= 1'b0;
      if (ctrl_wr)      ie_q   <= wr_ie_bit;
    end
  end
endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
  import bcd_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [BYTE_W-1:0] cur_sec,
  input  logic [BYTE_W-1:0] cur_min,
  input  logic [BYTE_W-1:0] cur_hour,
  input  logic [BYTE_W-1:0] cur_wday,
  input  logic [BYTE_W-1:0] cur_mday,
  input  logic [BYTE_W-1:0] cur_mon,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              alarm_irq
);
  localparam int unsigned ALM_LAST = ALM_BASE + FIELD_CNT - 1;

  logic [FIELD_CNT-1:0][BYTE_W-1:0] cur_vec;
  logic [FIELD_CNT-1:0][BYTE_W-1:0] alm_q;
  logic [FIELD_CNT-1:0]             wr_sel;
  logic                             ctrl_wr;
  logic                             hit_w;
  logic                             any_en_w;
  logic                             flag_q;
  logic                             ie_q;

  always_comb begin
    cur_vec[FLD_SEC]  = cur_sec;
    cur_vec[FLD_MIN]  = cur_min;
    cur_vec[FLD_HOUR] = cur_hour;
    cur_vec[FLD_WDAY] = cur_wday;
    cur_vec[FLD_MDAY] = cur_mday;
    cur_vec[FLD_MON]  = cur_mon;
  end

  for (genvar g = 0; g < FIELD_CNT; g++) begin : g_dec
    assign wr_sel[g] = reg_wr_en && (reg_addr == ADDR_W'(ALM_BASE + g));
  end
  assign ctrl_wr = reg_wr_en && (reg_addr == ADDR_W'(CTRL_IDX));

  bcd_alarm_regs #(.NFIELD(FIELD_CNT), .DW(BYTE_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (wr_sel),
    .wr_data (reg_wdata),
    .alm_q   (alm_q)
  );

  bcd_alarm_cmp_array #(.NFIELD(FIELD_CNT), .DW(BYTE_W)) u_cmp (
    .alm    (alm_q),
    .cur    (cur_vec),
    .any_en (any_en_w),
    .hit    (hit_w)
  );

  bcd_alarm_flag u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (sec_tick),
    .hit         (hit_w),
    .ctrl_wr     (ctrl_wr),
    .wr_flag_bit (reg_wdata[FLAG_BIT]),
    .wr_ie_bit   (reg_wdata[IE_BIT]),
    .flag_q      (flag_q),
    .ie_q        (ie_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr >= ADDR_W'(ALM_BASE) && reg_addr <= ADDR_W'(ALM_LAST)) begin
      for (int i = 0; i < FIELD_CNT; i++) begin
        if (reg_addr == ADDR_W'(ALM_BASE + i)) reg_rdata = alm_q[i];
      end
    end else if (reg_addr == ADDR_W'(CTRL_IDX)) begin
      reg_rdata[FLAG_BIT] = flag_q;
      reg_rdata[IE_BIT]   = ie_q;
    end
  end

  assign alarm_irq = flag_q && ie_q;
endmodule

// File: rtl/bcd_alarm_match_chk.sv
module bcd_alarm_match_chk
  import bcd_alarm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sec_tick,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic              hit_w,
  input logic              any_en_w,
  input logic              flag_q,
  input logic              alarm_irq
);
  logic clr_req;
  assign clr_req = reg_wr_en && (reg_addr == ADDR_W'(CTRL_IDX)) && !reg_wdata[FLAG_BIT];

  AST_SET_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(sec_tick)); // R6

  AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(any_en_w)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req) |=> flag_q); // R7

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !(sec_tick && hit_w)) |=> !flag_q); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && hit_w) |=> flag_q); // R8

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> flag_q); // R9
endmodule

bind bcd_alarm_match bcd_alarm_match_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sec_tick  (sec_tick),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .hit_w     (hit_w),
  .any_en_w  (any_en_w),
  .flag_q    (flag_q),
  .alarm_irq (alarm_irq)
);

// File: tb/bcd_alarm_match_tb_top.sv
module bcd_alarm_match_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [7:0] tcur [6];
  logic       reg_wr_en = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       alarm_irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] m_alm [6];
  int unsigned lim [6] = '{60, 60, 24, 7, 32, 13};

  always #2 clk = ~clk;

  bcd_alarm_match dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .cur_sec(tcur[0]), .cur_min(tcur[1]), .cur_hour(tcur[2]),
    .cur_wday(tcur[3]), .cur_mday(tcur[4]), .cur_mon(tcur[5]),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alarm_irq(alarm_irq)
  );

  task automatic report_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  function automatic logic [7:0] to_bcd(input int unsigned v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic model_hit();
    logic any = 1'b0;
    logic all = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (m_alm[i][7]) begin
        any = 1'b1;
        if (m_alm[i][6:0] != tcur[i][6:0] || tcur[i][7]) all = 1'b0;
      end
    end
    return any && all;
  endfunction

  task automatic load_alarm();
    for (int i = 0; i < 6; i++) wr(4'(8 + i), m_alm[i]);
  endtask

  task automatic chk_flag(input string req, input logic ef, input logic eie);
    logic [7:0] d;
    rd(4'd14, d);
    chk(req, d, {4'b0, eie, 2'b0, ef});
    chk(req, {7'b0, alarm_irq}, {7'b0, ef && eie});
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    report_end();
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h1A2B3C4D));
    for (int i = 0; i < 6; i++) tcur[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 8; i <= 14; i++) begin
      rd(4'(i), d);
      chk("R1 reset regs", d, 8'h00);
    end
    chk("R1 reset irq", {7'b0, alarm_irq}, 8'h00);

    // R2 readback in field order
    for (int i = 0; i < 6; i++) m_alm[i] = 8'h80 | 8'(i * 5 + 1);
    load_alarm();
    for (int i = 0; i < 6; i++) begin
      rd(4'(8 + i), d);
      chk("R2 readback", d, m_alm[i]);
    end

    // R10 unmapped index ignores writes, control spare bits read 0, R7 write 1 does not set
    wr(4'd3, 8'hFF);
    rd(4'd3, d); chk("R10 unmapped", d, 8'h00);
    rd(4'd15, d); chk("R10 unmapped", d, 8'h00);
    wr(4'd14, 8'hFF);
    chk_flag("R10/R7 ctrl write ones", 1'b0, 1'b1);

    // R5 no field enabled: alarm bytes written as 0, R4
    for (int i = 0; i < 6; i++) m_alm[i] = 8'h00;
    load_alarm();
    pulse_tick();
    chk_flag("R5 nothing enabled", 1'b0, 1'b1);

    // R4 disabled field with stale value, R3 enabled seconds match
    m_alm[0] = 8'hA5; m_alm[1] = 8'h42; m_alm[2] = 8'h13;
    load_alarm();
    tcur[0] = 8'h25; tcur[1] = 8'h07; tcur[2] = 8'h11;
    pulse_tick();
    chk_flag("R4 disabled field ignored", 1'b1, 1'b1);

    // R9 irq follows enable
    wr(4'd14, 8'h01);
    chk_flag("R9 irq masked", 1'b1, 1'b0);
    wr(4'd14, 8'h09);
    chk_flag("R9 irq unmasked", 1'b1, 1'b1);

    // R8 set and clear in same cycle
    @(negedge clk);
    sec_tick = 1'b1; reg_addr = 4'd14; reg_wdata = 8'h08; reg_wr_en = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0; reg_wr_en = 1'b0;
    chk_flag("R8 set wins", 1'b1, 1'b1);

    // R7 clear, R6 hold match without tick
    wr(4'd14, 8'h08);
    chk_flag("R7 clear", 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    chk_flag("R6 held match no tick", 1'b0, 1'b1);

    // R3 one-digit difference, and bit 7 of time byte set
    tcur[0] = 8'h24;
    pulse_tick();
    chk_flag("R3 digit mismatch", 1'b0, 1'b1);
    tcur[0] = 8'hA5;
    pulse_tick();
    chk_flag("R3 time bit7", 1'b0, 1'b1);

    // R5/R3/R4 random against model
    for (int it = 0; it < 60; it++) begin
      logic [7:0] v [6];
      logic e;
      for (int i = 0; i < 6; i++) begin
        v[i] = to_bcd($urandom % lim[i]);
        if ($urandom % 2) m_alm[i] = 8'h80 | v[i];
        else m_alm[i] = ($urandom % 2) ? v[i] : 8'h00;
      end
      load_alarm();
      wr(4'd14, 8'h08);
      for (int i = 0; i < 6; i++)
        tcur[i] = (m_alm[i][7] && ($urandom % 5 != 0)) ? v[i] : to_bcd($urandom % lim[i]);
      e = model_hit();
      pulse_tick();
      chk_flag("R5 random compare", e, 1'b1);
    end

    report_end();
  end
endmodule